// File: doc/BRIEF.md
# Serial Command Slave with Frame-Length Check

This block is the serial control port of a half-bridge driver controller. A host lowers chip select, toggles the serial clock and shifts a 16-bit command word into the data input, least significant bit first. During the same clocks the block shifts a 16-bit status word out on its data output. Each output bit leaves exactly sixteen clocks after it entered, so several devices can share one chip select in a daisy chain. In that arrangement the last sixteen bits that reach a device are its own command.

When chip select is released, the block counts the serial clock rising edges it saw. It commits the captured word to its control register only if that count is a nonzero multiple of sixteen and the serial clock is low at that moment. A committed frame also clears the latched fault flags. A re-latch pulse from an external fault filter then sets again the faults that are still present. The three pins are sampled with the system clock through a short synchroniser, so the serial clock must be much slower than the system clock. Output enable is a separate pin, so the pad cell can place the data output in high impedance.

Top module: `spi_frame_slave`

## Requirements
- R1: Reset (synchronous, active low) sets `ctrl_word` to 0, sets `fault_flags` to 0 and drives `sdo_oe` low.
- R2: In a frame of exactly 16 clocks, the bit present at the first rising serial clock becomes `ctrl_word[0]`, and the bit at the sixteenth becomes `ctrl_word[15]`. Bit 0 is the reset request, bits 1 to 6 are the six half-bridge enables, bit 14 disables overcurrent shutdown and bit 15 enables overvoltage lockout. The word is committed only after chip select returns high.
- R3: A frame of 32 or 48 clocks is accepted, and `ctrl_word` takes the last 16 bits received.
- R4: A frame of 0, 15 or 17 clocks, or any count that is not a nonzero multiple of 16, leaves `ctrl_word` unchanged.
- R5: A frame whose serial clock is high when chip select rises is rejected, and `ctrl_word` is unchanged.
- R6: An accepted frame sets `fault_flags` to 0. A rejected frame leaves them unchanged.
- R7: A pulse on `flt_relatch` ORs `flt_now` into `fault_flags`. If the pulse coincides with an accepted frame, the clear wins.
- R8: The status word is loaded when chip select falls, and bit 0 appears on `sdo` before the first clock. `sdo` moves to the next bit only on a falling serial clock. The status layout is: bit 0 thermal warning (`fault_flags[0]`), bits 1 to 6 a copy of `ctrl_word[6:1]`, bit 7 open load (`fault_flags[1]`), bit 8 underload (`fault_flags[2]`), bits 9 to 14 zero, and bit 15 supply failure (`fault_flags[3]`).
- R9: The bit taken in on `sdi` at clock k appears on `sdo` for clock k+16, so bits 16 to 31 of a 32-clock frame are the first 16 input bits.
- R10: `sdo_oe` is high only while a transfer is open, and it drops after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, LSB first |
| flt_now | input | 4 | Present fault conditions (thermal, open load, underload, supply) |
| flt_relatch | input | 1 | One-cycle pulse from the fault filter that sets the present faults again |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad; low means high impedance |
| ctrl_word | output | 16 | Committed command register |
| fault_flags | output | 4 | Latched fault register |

## Verification
The assertions assume that every serial pin level is held for more system clocks than the synchroniser depth. They also assume that a chip-select edge and a serial-clock edge never reach the synchronised side in the same cycle. The stimulus holds each serial clock phase for eight system cycles and waits that long between a chip-select edge and the next clock edge. The relatch pulse is driven only while no transfer is open, so a clear and a relatch never fall in the same cycle. The bench therefore exercises the clear-wins ordering only through its assertion.

// File: rtl/spi_frame_pkg.sv
// Package: shared constants for the serial frame slave.
// Assumes the command and status layouts are 16 bits wide.
package spi_frame_pkg;
    localparam int WORD_W  = 16;
    localparam int FLT_W   = 4;
    localparam int CNT_W   = $clog2(WORD_W);

    // Fault flag positions inside the fault register.
    localparam int FLT_THERM = 0;
    localparam int FLT_OPEN  = 1;
    localparam int FLT_UNDER = 2;
    localparam int FLT_SUPPLY = 3;

    // Status word bit positions.
    localparam int ST_THERM  = 0;
    localparam int ST_OUT_LO = 1;
    localparam int ST_OUT_HI = 6;
    localparam int ST_OPEN   = 7;
    localparam int ST_UNDER  = 8;
    localparam int ST_SUPPLY = 15;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings N asynchronous pins into the system clock domain through
// STAGES flops each. Assumes pins stay stable longer than STAGES cycles.
module spi_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_lvl
);
    logic [N-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one synchroniser stage, resets to the pin idle level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= IDLE;
                else if (g == 0) chain_q[g] <= pin_in;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign pin_lvl = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
// Module: spi_frame_shifter
// Finds chip-select and serial-clock edges, samples data on the rising
// clock, shifts on the falling clock and checks the frame length at
// release. Assumes synchronised pin levels and a slow serial clock.
module spi_frame_shifter
    import spi_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sclk_lvl,
    input  logic              sdi_lvl,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] frame_word,
    output logic              commit,
    output logic              sdo,
    output logic              sdo_oe
);
    logic             cs_d, sclk_d;
    logic             cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic             active_q;
    logic [CNT_W-1:0] cnt_lo_q;
    logic             cnt_any_q;
    logic             smp_q, pend_q;
    logic [WORD_W-1:0] shreg_q;
    logic             len_ok;

    // Purpose: previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_lvl;
            sclk_d <= sclk_lvl;
        end
    end

    always_comb begin
        cs_fall   = cs_d & ~cs_lvl;
        cs_rise   = ~cs_d & cs_lvl;
        sclk_rise = ~sclk_d & sclk_lvl;
        sclk_fall = sclk_d & ~sclk_lvl;
    end

    // Purpose: transfer window, bit counter and input sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            cnt_lo_q  <= '0;
            cnt_any_q <= 1'b0;
            smp_q     <= 1'b0;
            pend_q    <= 1'b0;
        end else if (cs_fall) begin
            active_q  <= 1'b1;
            cnt_lo_q  <= '0;
            cnt_any_q <= 1'b0;
            pend_q    <= 1'b0;
        end else if (cs_rise) begin
            active_q  <= 1'b0;
            pend_q    <= 1'b0;
        end else if (active_q && sclk_rise) begin
            cnt_lo_q  <= cnt_lo_q + 1'b1;
            cnt_any_q <= 1'b1;
            smp_q     <= sdi_lvl;
            pend_q    <= 1'b1;
        end else if (active_q && sclk_fall) begin
            pend_q    <= 1'b0;
        end
    end

    // Purpose: status load at select and shift on each falling clock.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= '0;
        else if (cs_fall) shreg_q <= status_word;
        else if (active_q && sclk_fall && pend_q)
            shreg_q <= {smp_q, shreg_q[WORD_W-1:1]};
    end

    // Whole words, at least one, and clock idle low at release.
    assign len_ok     = cnt_any_q && (cnt_lo_q == '0) && !sclk_lvl;
    assign commit     = active_q && cs_rise && len_ok;
    assign frame_word = shreg_q;
    assign sdo        = shreg_q[0];
    assign sdo_oe     = active_q;

    // R10: output enable drops after release.
    a_r10_oe_off_after_release: assert property (@(posedge clk)
        disable iff (!rst_n) cs_rise |=> !sdo_oe);

    // R8: data out only moves on a falling clock or a select edge.
    a_r8_sdo_moves_on_fall: assert property (@(posedge clk)
        disable iff (!rst_n)
        (active_q && !sclk_fall && !cs_fall && !cs_rise) |=> $stable(sdo));
endmodule

// File: rtl/spi_fault_latch.sv
// Module: spi_fault_latch
// Holds the fault flags. A relatch pulse sets present faults; a committed
// frame clears all flags and takes priority. Assumes one-cycle pulses.
module spi_fault_latch
    import spi_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             relatch,
    input  logic [FLT_W-1:0] flt_now,
    output logic [FLT_W-1:0] flags
);
    // Purpose: clear on accepted frame, else OR in present faults.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else if (clear) flags <= '0;
        else if (relatch) flags <= flags | flt_now;
    end

    // R6: accepted frame empties the register.
    a_r6_clear_on_commit: assert property (@(posedge clk)
        disable iff (!rst_n) clear |=> (flags == '0));

    // R7: relatch sets every present fault.
    a_r7_relatch_sets: assert property (@(posedge clk)
        disable iff (!rst_n)
        (relatch && !clear) |=> ((flags & $past(flt_now)) == $past(flt_now)));
endmodule

// File: rtl/spi_frame_slave.sv
// Module: spi_frame_slave (top)
// Serial command slave: synchronises pins, shifts frames, commits the
// command word on a valid length and manages the fault flags.
// Assumes the serial clock is far slower than clk.
module spi_frame_slave
    import spi_frame_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [FLT_W-1:0]  flt_now,
    input  logic              flt_relatch,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [FLT_W-1:0]  fault_flags
);
    logic [2:0]        lvl;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] frame_word;
    logic              commit;

    spi_pin_sync #(
        .N(3), .STAGES(SYNC_STAGES), .IDLE(3'b001)
    ) i_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_in({sdi, sclk, cs_n}),
        .pin_lvl(lvl)
    );

    // Purpose: assemble the status word from flags and output states.
    always_comb begin
        status_word = '0;
        status_word[ST_THERM]  = fault_flags[FLT_THERM];
        status_word[ST_OUT_HI:ST_OUT_LO] = ctrl_word[ST_OUT_HI:ST_OUT_LO];
        status_word[ST_OPEN]   = fault_flags[FLT_OPEN];
        status_word[ST_UNDER]  = fault_flags[FLT_UNDER];
        status_word[ST_SUPPLY] = fault_flags[FLT_SUPPLY];
    end

    spi_frame_shifter i_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(lvl[0]), .sclk_lvl(lvl[1]), .sdi_lvl(lvl[2]),
        .status_word(status_word),
        .frame_word(frame_word),
        .commit(commit),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    spi_fault_latch i_fault (
        .clk(clk), .rst_n(rst_n),
        .clear(commit), .relatch(flt_relatch),
        .flt_now(flt_now), .flags(fault_flags)
    );

    // Purpose: command register, written only by an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_word <= '0;
        else if (commit) ctrl_word <= frame_word;
    end

    // R4: without a commit the command register holds.
    a_r4_hold_without_commit: assert property (@(posedge clk)
        disable iff (!rst_n) !commit |=> $stable(ctrl_word));
endmodule

// File: tb/test_spi_frame_slave.sv
module test_spi_frame_slave;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [3:0]  flt_now = '0;
    logic        flt_relatch = 1'b0;
    logic        sdo, sdo_oe;
    logic [15:0] ctrl_word;
    logic [3:0]  fault_flags;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [47:0] so_cap;
    logic        oe_mid;

    always #10 clk = ~clk;

    spi_frame_slave i_spi_frame_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .flt_now(flt_now), .flt_relatch(flt_relatch),
        .sdo(sdo), .sdo_oe(sdo_oe),
        .ctrl_word(ctrl_word), .fault_flags(fault_flags)
    );

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_status(input logic [15:0] c, input logic [3:0] f);
        logic [15:0] s = '0;
        s[0] = f[0]; s[6:1] = c[6:1]; s[7] = f[1]; s[8] = f[2]; s[15] = f[3];
        return s;
    endfunction

    task automatic send_frame(input int nbits, input logic [47:0] data, input bit end_high);
        so_cap = '0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = data[i];
            repeat (H) @(negedge clk);
            so_cap[i] = sdo;
            if (i == 0) oe_mid = sdo_oe;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            if (!(end_high && i == nbits - 1)) sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic pulse_relatch(input logic [3:0] f);
        flt_now = f;
        flt_relatch = 1'b1;
        @(negedge clk);
        flt_relatch = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 ctrl", ctrl_word, 0);
        check("R1 faults", fault_flags, 0);
        check("R1 oe", sdo_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_single();
        send_frame(16, 48'hA5C3, 0);
        check("R2 word", ctrl_word, 16'hA5C3);
        check("R8 status from reset", so_cap[15:0], exp_status(16'h0, 4'h0));
        check("R10 oe during frame", oe_mid, 1);
        check("R10 oe idle", sdo_oe, 0);
    endtask

    task automatic t_faults();
        pulse_relatch(4'b1011);
        check("R7 relatch", fault_flags, 4'b1011);
        send_frame(15, 48'h7FFF, 0);
        check("R4 15 bits", ctrl_word, 16'hA5C3);
        check("R6 kept on reject", fault_flags, 4'b1011);
        send_frame(16, 48'h407E, 0);
        check("R8 status", so_cap[15:0], exp_status(16'hA5C3, 4'b1011));
        check("R2 word 2", ctrl_word, 16'h407E);
        check("R6 cleared", fault_flags, 0);
        pulse_relatch(4'b0100);
        check("R7 relatch again", fault_flags, 4'b0100);
    endtask

    task automatic t_daisy();
        send_frame(32, {16'h0, 16'h3C96, 16'hBEEF}, 0);
        check("R3 32 bits", ctrl_word, 16'h3C96);
        check("R9 forward", so_cap[31:16], 16'hBEEF);
        check("R8 status first", so_cap[15:0], exp_status(16'h407E, 4'b0100));
    endtask

    task automatic t_lengths();
        send_frame(17, 48'h1FFFF, 0);
        check("R4 17 bits", ctrl_word, 16'h3C96);
        send_frame(0, 48'h0, 0);
        check("R4 zero bits", ctrl_word, 16'h3C96);
        send_frame(48, {16'h5A01, 16'h1111, 16'h2222}, 0);
        check("R3 48 bits", ctrl_word, 16'h5A01);
        check("R9 48 forward", so_cap[47:32], 16'h1111);
    endtask

    task automatic t_clock_high();
        pulse_relatch(4'b0001);
        send_frame(16, 48'h0F0F, 1);
        check("R5 clock high", ctrl_word, 16'h5A01);
        check("R6 kept on R5 reject", fault_flags, 4'b0001);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_faults();
        t_daisy();
        t_lengths();
        t_clock_high();
        t_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule